// File: doc/BRIEF.md
# Sixteen-Bit Function Unit with Sign and Zero Flags

This block is the combinational computing core of a small single-cycle processor datapath. It takes two 16-bit operands and a 4-bit function code. In one pass of logic it produces a 16-bit result, a sign flag and a zero flag. The operations are arithmetic (pass, increment, add, subtract, decrement), bitwise logic, and a one-position shifter. The shifter and the B pass-through act on the second operand, not the first. The second operand is either a register value or a small constant that is zero-filled upstream. The block has no state.

The function code splits into three decode groups. Codes with the top bit clear go to the arithmetic unit. Codes starting `10` go to the logic unit. Codes starting `11` go to the shifter and the B pass-through. Each group unit flags whether it recognises the code. A code that no unit claims yields a zero result.

Top module: `fu_core`

## Requirements
- R1: Code 0000 outputs operand A unchanged, and code 0001 outputs A plus one.
- R2: Code 0010 outputs A+B, code 0101 outputs A−B, and code 0110 outputs A−1. All three are taken modulo 2^16 in two's complement. A small B such as 7 added to 0xFFF9 wraps to 0.
- R3: Code 1000 outputs A AND B, 1001 outputs A OR B, 1010 outputs A XOR B, and 1011 outputs the bitwise inverse of A.
- R4: Code 1100 outputs B. Code 1101 outputs B shifted right by one with bit 15 filled by 0. Code 1110 outputs B shifted left by one with bit 0 filled by 0. Fifteen left shifts of 0x0001 reach 0x8000, and a sixteenth gives 0.
- R5: The sign flag equals bit 15 of the result for every code.
- R6: The zero flag is 1 exactly when all 16 result bits are 0.
- R7: Codes 0011, 0100, 0111 and 1111 give a result of 0, so the zero flag is 1 and the sign flag is 0, whatever the operands.
- R8: Incrementing 0xFFFF gives 0 with the zero flag set. Decrementing 0 gives 0xFFFF with the sign flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand (A) |
| opnd_b | input | 16 | Second operand (B): register value or zero-filled constant |
| fsel | input | 4 | Function code |
| result | output | 16 | Operation result |
| neg_flag | output | 1 | Sign flag, bit 15 of the result |
| zero_flag | output | 1 | Set when the result is all zeros |

## Verification
The hardest case to reach from the ports is a shifter chain that drives a set bit all the way out of the word. A single vector shows one step and cannot show that the fill bit stays clean over many shifts. The bench therefore feeds each left-shift result back in as the next B operand, starting from 0x0001. It checks the result and the sign flag at every step until the sixteenth shift leaves zero. The wrap cases at 0xFFFF and 0, and the four unclaimed codes driven with all-ones operands, make up the rest of the boundary set.

// File: rtl/fu_pkg.sv
package fu_pkg;

    localparam int unsigned FU_WIDTH = 16;
    localparam int unsigned FU_SEL_W = 4;

    typedef enum logic [FU_SEL_W-1:0] {
        FN_PASSA = 4'b0000,
        FN_INC   = 4'b0001,
        FN_ADD   = 4'b0010,
        FN_SUB   = 4'b0101,
        FN_DEC   = 4'b0110,
        FN_AND   = 4'b1000,
        FN_OR    = 4'b1001,
        FN_XOR   = 4'b1010,
        FN_NOTA  = 4'b1011,
        FN_PASSB = 4'b1100,
        FN_SHR   = 4'b1101,
        FN_SHL   = 4'b1110
    } fu_op_e;

endpackage

// File: rtl/fu_arith.sv
module fu_arith
    import fu_pkg::*;
#(
    parameter int unsigned W = FU_WIDTH
) (
    input  logic [W-1:0]        a,
    input  logic [W-1:0]        b,
    input  logic [FU_SEL_W-1:0] op,
    output logic [W-1:0]        res,
    output logic                hit
);

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONES = '1;

    logic [W-1:0] addend;
    logic         cin;

    // Every arithmetic code is one adder pass with a chosen addend and carry-in.
    always_comb begin
        addend = ZERO;
        cin    = 1'b0;
        hit    = 1'b1;
        unique case (op)
            FN_PASSA: begin addend = ZERO; cin = 1'b0; end
            FN_INC:   begin addend = ZERO; cin = 1'b1; end
            FN_ADD:   begin addend = b;    cin = 1'b0; end
            FN_SUB:   begin addend = ~b;   cin = 1'b1; end
            FN_DEC:   begin addend = ONES; cin = 1'b0; end
            default:  hit = 1'b0;
        endcase
    end

    assign res = a + addend + {{(W-1){1'b0}}, cin};

    always_comb begin
        if (hit && op == FN_ADD) begin
            assert_add_inverse_R2: assert (res - b == a);
        end
        if (hit && op == FN_SUB) begin
            assert_sub_inverse_R2: assert (res + b == a);
        end
        if (hit && op == FN_INC && a == ONES) begin
            assert_inc_wrap_R8: assert (res == ZERO);
        end
    end

endmodule

// File: rtl/fu_logic.sv
module fu_logic
    import fu_pkg::*;
#(
    parameter int unsigned W = FU_WIDTH
) (
    input  logic [W-1:0]        a,
    input  logic [W-1:0]        b,
    input  logic [FU_SEL_W-1:0] op,
    output logic [W-1:0]        res,
    output logic                hit
);

    always_comb begin
        res = '0;
        hit = 1'b1;
        unique case (op)
            FN_AND:  res = a & b;
            FN_OR:   res = a | b;
            FN_XOR:  res = a ^ b;
            FN_NOTA: res = ~a;
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        if (hit && op == FN_XOR) begin
            assert_xor_undo_R3: assert ((res ^ b) == a);
        end
        if (hit && op == FN_NOTA) begin
            assert_not_disjoint_R3: assert ((res & a) == '0 && (res | a) == '1);
        end
    end

endmodule

// File: rtl/fu_shift.sv
module fu_shift
    import fu_pkg::*;
#(
    parameter int unsigned W = FU_WIDTH
) (
    input  logic [W-1:0]        b,
    input  logic [FU_SEL_W-1:0] op,
    output logic [W-1:0]        res,
    output logic                hit
);

    always_comb begin
        res = '0;
        hit = 1'b1;
        unique case (op)
            FN_PASSB: res = b;
            FN_SHR:   res = {1'b0, b[W-1:1]};
            FN_SHL:   res = {b[W-2:0], 1'b0};
            default:  hit = 1'b0;
        endcase
    end

    always_comb begin
        if (hit && op == FN_SHR) begin
            assert_shr_msb_clear_R4: assert (res[W-1] == 1'b0);
        end
        if (hit && op == FN_SHL) begin
            assert_shl_lsb_clear_R4: assert (res[0] == 1'b0);
        end
    end

endmodule

// File: rtl/fu_core.sv
module fu_core
    import fu_pkg::*;
#(
    parameter int unsigned W = FU_WIDTH
) (
    input  logic [W-1:0]        opnd_a,
    input  logic [W-1:0]        opnd_b,
    input  logic [FU_SEL_W-1:0] fsel,
    output logic [W-1:0]        result,
    output logic                neg_flag,
    output logic                zero_flag
);

    logic [W-1:0] ar_res, lg_res, sh_res;
    logic         ar_hit, lg_hit, sh_hit;

    fu_arith #(.W(W)) u_arith (
        .a(opnd_a), .b(opnd_b), .op(fsel), .res(ar_res), .hit(ar_hit)
    );

    fu_logic #(.W(W)) u_logic (
        .a(opnd_a), .b(opnd_b), .op(fsel), .res(lg_res), .hit(lg_hit)
    );

    fu_shift #(.W(W)) u_shift (
        .b(opnd_b), .op(fsel), .res(sh_res), .hit(sh_hit)
    );

    // Result steering: a code no unit claims yields zero.
    always_comb begin
        unique case ({ar_hit, lg_hit, sh_hit})
            3'b100:  result = ar_res;
            3'b010:  result = lg_res;
            3'b001:  result = sh_res;
            default: result = '0;
        endcase
    end

    assign neg_flag  = result[W-1];
    assign zero_flag = (result == '0);

    always_comb begin
        assert_one_owner_R7: assert ($onehot0({ar_hit, lg_hit, sh_hit}));
        assert_flags_exclusive_R6: assert (!(zero_flag && neg_flag));
        if (!(ar_hit || lg_hit || sh_hit)) begin
            assert_unclaimed_zero_R7: assert (zero_flag && !neg_flag);
        end
    end

endmodule

// File: tb/fu_core_test.sv
module fu_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a, b;
    logic [3:0]  fs;
    logic [15:0] f;
    logic        n, z;
    int          tests  = 0;
    int          failed = 0;
    int          cycles = 0;
    bit          done   = 0;

    always #10 clk = ~clk;  // 50 MHz

    fu_core uut (
        .opnd_a(a), .opnd_b(b), .fsel(fs),
        .result(f), .neg_flag(n), .zero_flag(z)
    );

    // Fields: {req[3:0], fs[3:0], a[15:0], b[15:0], expected[15:0]}
    localparam int NV = 24;
    localparam logic [55:0] VECS [NV] = '{
        {4'd1, 4'b0000, 16'h8123, 16'h5555, 16'h8123}, // R1 pass A
        {4'd1, 4'b0001, 16'h00FF, 16'h1234, 16'h0100}, // R1 increment
        {4'd8, 4'b0001, 16'hFFFF, 16'h0000, 16'h0000}, // R8 increment wraps
        {4'd2, 4'b0010, 16'h1234, 16'h0007, 16'h123B}, // R2 add
        {4'd2, 4'b0010, 16'h8000, 16'h8000, 16'h0000}, // R2 add overflow
        {4'd2, 4'b0010, 16'hFFF9, 16'h0007, 16'h0000}, // R2 add constant 7 wraps
        {4'd2, 4'b0101, 16'h0005, 16'h0007, 16'hFFFE}, // R2 subtract negative
        {4'd2, 4'b0101, 16'h7000, 16'h1000, 16'h6000}, // R2 subtract
        {4'd8, 4'b0110, 16'h0000, 16'h5A5A, 16'hFFFF}, // R8 decrement wraps
        {4'd2, 4'b0110, 16'h0100, 16'h0000, 16'h00FF}, // R2 decrement
        {4'd3, 4'b1000, 16'hF0F0, 16'h3C3C, 16'h3030}, // R3 and
        {4'd3, 4'b1001, 16'hF0F0, 16'h3C3C, 16'hFCFC}, // R3 or
        {4'd3, 4'b1010, 16'hF0F0, 16'h3C3C, 16'hCCCC}, // R3 xor
        {4'd3, 4'b1011, 16'hF0F0, 16'h3C3C, 16'h0F0F}, // R3 not A
        {4'd3, 4'b1011, 16'hFFFF, 16'h0000, 16'h0000}, // R3 not all-ones
        {4'd4, 4'b1100, 16'h1111, 16'h9ABC, 16'h9ABC}, // R4 pass B
        {4'd4, 4'b1101, 16'hFFFF, 16'h8001, 16'h4000}, // R4 shift right
        {4'd4, 4'b1110, 16'h0000, 16'h8001, 16'h0002}, // R4 shift left
        {4'd4, 4'b1110, 16'h0000, 16'hC000, 16'h8000}, // R4 shift left sign
        {4'd4, 4'b1101, 16'h0000, 16'h0001, 16'h0000}, // R4 shift right out
        {4'd7, 4'b0011, 16'hFFFF, 16'hFFFF, 16'h0000}, // R7 unclaimed
        {4'd7, 4'b0100, 16'hFFFF, 16'hFFFF, 16'h0000}, // R7 unclaimed
        {4'd7, 4'b0111, 16'hFFFF, 16'hFFFF, 16'h0000}, // R7 unclaimed
        {4'd7, 4'b1111, 16'hFFFF, 16'hFFFF, 16'h0000}  // R7 unclaimed
    };

    task automatic check_out(input int req, input logic [15:0] exp);
        tests++;
        if (f !== exp) begin
            failed++;
            $display("FAIL R%0d result: fs=%b a=%h b=%h got %h expected %h",
                     req, fs, a, b, f, exp);
        end
        tests++;
        if (n !== exp[15]) begin  // R5 sign flag
            failed++;
            $display("FAIL R5 sign flag: fs=%b got %b expected %b", fs, n, exp[15]);
        end
        tests++;
        if (z !== (exp == 16'h0000)) begin  // R6 zero flag
            failed++;
            $display("FAIL R6 zero flag: fs=%b got %b expected %b", fs, z, (exp == 16'h0000));
        end
    endtask

    task automatic apply(input logic [3:0] fsv, input logic [15:0] av, input logic [15:0] bv);
        @(posedge clk);
        fs = fsv; a = av; b = bv;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            failed++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        fs = 4'b0000; a = '0; b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_out(1, 16'h0000); // R1 and R6: idle inputs give zero result

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][51:48], VECS[i][47:32], VECS[i][31:16]);
            check_out(int'(VECS[i][55:52]), VECS[i][15:0]);
        end

        // R4 corner: chain sixteen left shifts, feeding each result back as B.
        begin
            logic [15:0] cur;
            logic [15:0] exp;
            cur = 16'h0001;
            for (int s = 1; s <= 16; s++) begin
                apply(4'b1110, 16'hFFFF, cur);
                exp = (s < 16) ? (16'h0001 << s) : 16'h0000;
                check_out(4, exp);
                cur = f;
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule